// File: doc/BRIEF.md
# Connector Mode Switch Configuration Sequencer

This block sits on the host side of a high-speed connector crossbar switch. It takes a requested connector mode (port role, pin assignment and plug orientation) over a request/acknowledge handshake. It then issues the ordered sequence of byte register writes that sets up the switch, over a simple address/data valid/ready command port. An I2C controller downstream turns those commands into bus transactions. That controller is outside this block.

Each configuration is a fixed burst of eight writes. System control comes first, then the four high-speed output selects, then the sideband output select and the sideband cross/pass control, and last a single commit write. The commit makes the switch adopt the preloaded selects. Plug orientation is not handled as a separate mode table. It is expressed by swapping the selects of output pairs 1/2 and 3/4 and by swapping the sideband cross/pass setting. A change from one active lane assignment to a different one always passes through a committed safe configuration first. A request the switch cannot carry is refused with an error pulse, and no write is issued for it.

Top module: `xsw_seq`

## Requirements
- R1: After reset, `wr_valid`, `req_ack` and `req_err` are all low, and they stay low while no request is presented.
- R2: A configuration burst writes addresses 0x01 to 0x08 in strictly increasing order: system control 0x01, output selects 0x02..0x05 for outputs 1..4, sideband output select 0x06, cross control 0x07, commit 0x08. Every select and cross write therefore precedes the commit.
- R3: Every burst writes 0x80 to system control and 0x3F to commit. The sideband output select is 0x40 for assignments C, D and E and 0x00 for safe and USB-only.
- R4: Assignment C (code 2), for either role, selects 0x02, 0x04, 0x10, 0x20 on outputs 1..4 with cross 0x01 when normal (`req_flip`=0). When flipped (`req_flip`=1) it selects 0x04, 0x02, 0x20, 0x10 with cross 0x02.
- R5: Assignment D (code 3), for either role, selects 0x01, 0x04, 0x08, 0x20 with cross 0x01 when normal. When flipped it selects 0x04, 0x01, 0x20, 0x08 with cross 0x02.
- R6: Assignment E (code 4), upstream role only (`req_role`=1), uses the output selects of assignment C for the same orientation. Its cross setting is reversed: 0x02 when normal, 0x01 when flipped.
- R7: Safe mode (code 0) writes 0x00 to all five output selects and to cross control.
- R8: USB-only mode (code 1) selects 0x01 on output 1 and 0x08 on output 3 when normal. When flipped it selects 0x01 on output 2 and 0x08 on output 4. All other selects and cross control are 0x00.
- R9: If the last committed configuration and the requested one are both active assignments (C, D or E) and differ in role, assignment or orientation, a full safe burst is committed first, followed by the requested burst. Otherwise only the requested burst is written.
- R10: `req_ack` pulses high for exactly one cycle, in the cycle after the final commit write is accepted. It is never high together with `req_err`.
- R11: Assignment codes 5..7, and assignment E with the downstream role (`req_role`=0), are refused. The block pulses `req_err` for one cycle, issues no write, and leaves the last committed configuration unchanged.
- R12: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Mode request present; held until `req_ack` or `req_err` |
| req_role | input | 1 | 0 = downstream facing, 1 = upstream facing |
| req_asg | input | 3 | 0 safe, 1 USB-only, 2 C, 3 D, 4 E |
| req_flip | input | 1 | 0 = normal, 1 = flipped plug |
| req_ack | output | 1 | One-cycle pulse: configuration committed |
| req_err | output | 1 | One-cycle pulse: request refused |
| wr_valid | output | 1 | Register write command valid |
| wr_ready | input | 1 | Write command accepted by the bus controller |
| wr_addr | output | 8 | Register address |
| wr_data | output | 8 | Register data |

## Verification
Every assignment is requested in both orientations. The normal and flipped runs tell apart the pair-swap of the output selects and the direction of the cross setting, and the C and E runs are compared to separate the reversed sideband cross from the shared lane selects. Request sequences alternate between active, safe and USB-only modes and repeat one configuration. This distinguishes the cases where a safe burst must be inserted from those where it must not. Refused combinations are placed between valid ones, which shows that they neither write nor disturb the committed state. The write port is stalled on a fixed rhythm throughout, so that held commands and acceptance-driven ordering are exercised on every burst.

// File: rtl/xsw_pkg.sv
package xsw_pkg;

  localparam int NUM_WR = 8;
  localparam int IDX_W  = $clog2(NUM_WR);

  localparam logic [2:0] ASG_SAFE = 3'd0;
  localparam logic [2:0] ASG_USB  = 3'd1;
  localparam logic [2:0] ASG_C    = 3'd2;
  localparam logic [2:0] ASG_D    = 3'd3;
  localparam logic [2:0] ASG_E    = 3'd4;

  typedef struct packed {
    logic       role;   // 1 = upstream facing
    logic [2:0] asg;
    logic       flip;
  } xsw_cfg_t;

  localparam xsw_cfg_t SAFE_CFG = '{role: 1'b0, asg: ASG_SAFE, flip: 1'b0};

  function automatic logic cfg_supported(xsw_cfg_t c);
    return (c.asg <= ASG_E) && !(c.asg == ASG_E && !c.role);
  endfunction

  function automatic logic cfg_active(xsw_cfg_t c);
    return (c.asg == ASG_C) || (c.asg == ASG_D) || (c.asg == ASG_E);
  endfunction

  // Lane select for logical slot k (normal orientation numbering)
  function automatic logic [7:0] lane_base(logic [2:0] asg, logic [1:0] k);
    logic [7:0] v;
    v = 8'h00;
    case (asg)
      ASG_C, ASG_E: case (k) 2'd0: v = 8'h02; 2'd1: v = 8'h04; 2'd2: v = 8'h10; default: v = 8'h20; endcase
      ASG_D:        case (k) 2'd0: v = 8'h01; 2'd1: v = 8'h04; 2'd2: v = 8'h08; default: v = 8'h20; endcase
      ASG_USB:      case (k) 2'd0: v = 8'h01; 2'd2: v = 8'h08; default: v = 8'h00; endcase
      default:      v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic [7:0] cross_value(xsw_cfg_t c);
    logic [7:0] v;
    case (c.asg)
      ASG_C, ASG_D: v = c.flip ? 8'h02 : 8'h01;
      ASG_E:        v = c.flip ? 8'h01 : 8'h02;
      default:      v = 8'h00;
    endcase
    return v;
  endfunction

  // Data byte for burst step idx
  function automatic logic [7:0] step_data(xsw_cfg_t c, logic [IDX_W-1:0] idx);
    logic [1:0] k;
    logic [7:0] v;
    k = 2'(idx - IDX_W'(1));
    if (c.flip) k = k ^ 2'b01;
    case (idx)
      IDX_W'(0): v = 8'h80;
      IDX_W'(1), IDX_W'(2), IDX_W'(3), IDX_W'(4): v = lane_base(c.asg, k);
      IDX_W'(5): v = cfg_active(c) ? 8'h40 : 8'h00;
      IDX_W'(6): v = cross_value(c);
      default:   v = 8'h3F;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/xsw_cfg_table.sv
module xsw_cfg_table
  import xsw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 1
) (
  input  xsw_cfg_t          cfg,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);
  always_comb begin
    addr = ADDR_W'(BASE_ADDR) + ADDR_W'(idx);
    data = step_data(cfg, idx);
  end
endmodule

// File: rtl/xsw_seq_ctrl.sv
module xsw_seq_ctrl
  import xsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  xsw_cfg_t         req_cfg,
  input  logic             wr_ready,
  output logic             wr_valid,
  output logic [IDX_W-1:0] idx,
  output xsw_cfg_t         cur_cfg,
  output logic             req_ack,
  output logic             req_err,
  output logic             accept_evt,
  output logic             commit_fire
);
  typedef enum logic [1:0] {S_IDLE, S_WR, S_ACK, S_ERR} st_e;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WR - 1);

  st_e      st;
  xsw_cfg_t tgt_cfg, last_cfg;
  logic     chain;
  logic     need_safe;

  assign need_safe   = cfg_active(last_cfg) && cfg_active(req_cfg) && (last_cfg != req_cfg);
  assign accept_evt  = (st == S_IDLE) && req_valid;
  assign wr_valid    = (st == S_WR);
  assign commit_fire = wr_valid && wr_ready && (idx == LAST_IDX);
  assign req_ack     = (st == S_ACK);
  assign req_err     = (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      cur_cfg  <= SAFE_CFG;
      tgt_cfg  <= SAFE_CFG;
      last_cfg <= SAFE_CFG;
      chain    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          if (!cfg_supported(req_cfg)) st <= S_ERR;
          else begin
            st      <= S_WR;
            idx     <= '0;
            tgt_cfg <= req_cfg;
            chain   <= need_safe;
            cur_cfg <= need_safe ? SAFE_CFG : req_cfg;
          end
        end
        S_WR: if (wr_ready) begin
          if (idx == LAST_IDX) begin
            idx <= '0;
            if (chain) begin
              chain   <= 1'b0;
              cur_cfg <= tgt_cfg;
            end else begin
              st       <= S_ACK;
              last_cfg <= tgt_cfg;
            end
          end else idx <= idx + IDX_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xsw_seq.sv
module xsw_seq
  import xsw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_role,
  input  logic [2:0]        req_asg,
  input  logic              req_flip,
  output logic              req_ack,
  output logic              req_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  xsw_cfg_t         req_cfg, cur_cfg;
  logic [IDX_W-1:0] idx;
  logic             accept_evt, commit_fire;

  assign req_cfg = '{role: req_role, asg: req_asg, flip: req_flip};

  xsw_seq_ctrl u_ctrl (
    .clk, .rst_n, .req_valid, .req_cfg, .wr_ready,
    .wr_valid, .idx, .cur_cfg, .req_ack, .req_err,
    .accept_evt, .commit_fire
  );

  xsw_cfg_table #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_table (
    .cfg(cur_cfg), .idx, .addr(wr_addr), .data(wr_data)
  );
endmodule

// File: rtl/xsw_seq_chk.sv
module xsw_seq_chk #(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ack,
  input logic              req_err,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              commit_fire
);
  localparam logic [ADDR_W-1:0] SYS_A = ADDR_W'(BASE_ADDR);

  p_ack_after_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> $past(commit_fire));
  p_ack_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ack && req_err));
  p_err_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!wr_valid && $past(!wr_valid)));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !commit_fire) |=> (wr_valid && wr_addr == $past(wr_addr) + ADDR_W'(1)));
  p_sys_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == SYS_A) |-> wr_data == 8'h80);
  p_commit_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> wr_data == 8'h3F);
endmodule

bind xsw_seq xsw_seq_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk, .rst_n, .req_ack, .req_err, .wr_valid, .wr_ready,
  .wr_addr, .wr_data, .commit_fire
);

// File: tb/xsw_seq_tb.sv
module xsw_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_role = 1'b0, req_flip = 1'b0, wr_ready = 1'b0;
  logic [2:0] req_asg = 3'd0;
  logic req_ack, req_err, wr_valid;
  logic [7:0] wr_addr, wr_data;

  int checks = 0, errors = 0, cycles = 0;
  logic [4:0] last_m = 5'd0;   // model of last committed {role,asg,flip}

  always #10 clk = ~clk;

  xsw_seq u_dut (.clk, .rst_n, .req_valid, .req_role, .req_asg, .req_flip,
                 .req_ack, .req_err, .wr_valid, .wr_ready, .wr_addr, .wr_data);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_act(input logic [2:0] a);
    return a == 3'd2 || a == 3'd3 || a == 3'd4;
  endfunction

  // Independent restatement: explicit per-mode lists
  function automatic logic [7:0] model(input logic role, input logic [2:0] a,
                                       input logic fl, input int i);
    logic [7:0] o1, o2, o3, o4, o5, x;
    o1 = 0; o2 = 0; o3 = 0; o4 = 0; o5 = 0; x = 0;
    case ({a, fl})
      {3'd1,1'b0}: begin o1 = 8'h01; o3 = 8'h08; end
      {3'd1,1'b1}: begin o2 = 8'h01; o4 = 8'h08; end
      {3'd2,1'b0}: begin o1 = 8'h02; o2 = 8'h04; o3 = 8'h10; o4 = 8'h20; x = 8'h01; end
      {3'd2,1'b1}: begin o1 = 8'h04; o2 = 8'h02; o3 = 8'h20; o4 = 8'h10; x = 8'h02; end
      {3'd3,1'b0}: begin o1 = 8'h01; o2 = 8'h04; o3 = 8'h08; o4 = 8'h20; x = 8'h01; end
      {3'd3,1'b1}: begin o1 = 8'h04; o2 = 8'h01; o3 = 8'h20; o4 = 8'h08; x = 8'h02; end
      {3'd4,1'b0}: begin o1 = 8'h02; o2 = 8'h04; o3 = 8'h10; o4 = 8'h20; x = 8'h02; end
      {3'd4,1'b1}: begin o1 = 8'h04; o2 = 8'h02; o3 = 8'h20; o4 = 8'h10; x = 8'h01; end
      default: ;
    endcase
    if (is_act(a)) o5 = 8'h40;
    case (i)
      0: return 8'h80;
      1: return o1;
      2: return o2;
      3: return o3;
      4: return o4;
      5: return o5;
      6: return x;
      default: return 8'h3F;
    endcase
  endfunction

  // One scenario: present a request, collect writes under stalls, compare
  task automatic run(input logic role, input logic [2:0] a, input logic fl, input string tag);
    bit sup, safe_first, got_ack, got_err, done, pv, pr;
    int n_exp, n = 0;
    logic [7:0] ga[16], gd[16];
    logic [7:0] pa, pd;
    sup = (a <= 3'd4) && !(a == 3'd4 && !role);
    safe_first = sup && is_act(last_m[3:1]) && is_act(a) && (last_m != {role, a, fl});
    n_exp = !sup ? 0 : (safe_first ? 16 : 8);
    got_ack = 0; got_err = 0; done = 0; pv = 0; pr = 1; pa = 0; pd = 0;
    @(negedge clk);
    req_role = role; req_asg = a; req_flip = fl; req_valid = 1'b1;
    for (int k = 0; k < 200 && !done; k++) begin
      @(negedge clk);
      if (pv && !pr)
        chk(wr_valid && wr_addr == pa && wr_data == pd, {tag, " R12 hold"},
            {wr_valid, wr_addr, wr_data}, {1'b1, pa, pd});
      wr_ready = (k % 3 != 1);
      if (wr_valid && wr_ready) begin
        if (n < 16) begin ga[n] = wr_addr; gd[n] = wr_data; end
        n++;
      end
      if (req_ack) got_ack = 1;
      if (req_err) got_err = 1;
      if (req_ack || req_err) done = 1;
      pv = wr_valid; pr = wr_ready; pa = wr_addr; pd = wr_data;
    end
    req_valid = 1'b0; wr_ready = 1'b0;
    chk(got_ack == sup, {tag, " R10 ack"}, got_ack, sup);
    chk(got_err == !sup, {tag, " R11 err"}, got_err, !sup);
    chk(n == n_exp, {tag, " R9 write count"}, n, n_exp);
    for (int i = 0; i < n_exp && i < n; i++) begin
      logic [7:0] ed;
      ed = (safe_first && i < 8) ? model(1'b0, 3'd0, 1'b0, i % 8) : model(role, a, fl, i % 8);
      chk(ga[i] == 8'(1 + i % 8), {tag, " R2 addr"}, ga[i], 1 + i % 8);
      chk(gd[i] == ed, {tag, $sformatf(" data step %0d", i)}, gd[i], ed);
    end
    @(negedge clk);
    chk(!req_ack && !req_err && !wr_valid, {tag, " R10 single pulse"},
        {req_ack, req_err, wr_valid}, 0);
    if (sup) last_m = {role, a, fl};
  endtask

  task automatic reset_check();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!wr_valid && !req_ack && !req_err, "R1 idle after reset",
          {wr_valid, req_ack, req_err}, 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    reset_check();
    run(1'b0, 3'd0, 1'b0, "R7 safe");
    run(1'b0, 3'd1, 1'b0, "R8 usb normal");
    run(1'b1, 3'd1, 1'b1, "R8 usb flipped");
    run(1'b0, 3'd2, 1'b0, "R4 dfp C normal");
    run(1'b0, 3'd2, 1'b1, "R4 R9 dfp C flipped");
    run(1'b0, 3'd3, 1'b0, "R5 R9 dfp D normal");
    run(1'b1, 3'd3, 1'b1, "R5 ufp D flipped");
    run(1'b1, 3'd4, 1'b0, "R6 ufp E normal");
    run(1'b1, 3'd4, 1'b0, "R9 repeat same");
    run(1'b0, 3'd4, 1'b0, "R11 dfp E refused");
    run(1'b1, 3'd6, 1'b0, "R11 code 6 refused");
    run(1'b1, 3'd2, 1'b0, "R3 R9 ufp C after refusals");
    run(1'b1, 3'd4, 1'b1, "R6 ufp E flipped");
    run(1'b1, 3'd1, 1'b0, "R9 usb no safe");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule